// File: doc/BRIEF.md
# DRAM Controller Off-Mode Sequencer

This block takes a DRAM controller through power-off and back. A power-down request first stops new traffic and waits until every queue in the controller is empty. The block then commands the DRAM into self-refresh and loads the working configuration registers from their shadow copies. It waits until no interrupt is pending and only then raises the acknowledge. After the acknowledge, the system may assert module reset and remove clocks and power. If the request is withdrawn before the acknowledge, the block takes the DRAM out of self-refresh and returns to normal service.

The wake indication is sampled while reset is held. If it is set, the block skips DRAM initialization and starts in self-refresh. It stays there until software pulses a restore-done input. It then issues the self-refresh exit command and waits a programmable number of cycles before it grants memory access. A cold reset without the wake indication runs a fixed-length initialization instead. A PHY clock-gate control is honoured only while the DRAM is in self-refresh.

Top module: `mc_offmode_seq`

## Requirements
- R1: After a cold reset (wake_from_off low during reset), access_en is 0 for exactly INIT_CYCLES cycles after reset is released, then becomes 1; pd_ack, self_refresh and woke are 0.
- R2: While pd_req is high and queues_empty is low, access_en is 0 and sr_enter stays low; sr_enter pulses for one cycle only after queues_empty was seen high.
- R3: The cycle after the sr_enter pulse, shadow_load pulses for one cycle. This single strobe loads all five shadowed registers (refresh control, timing 1, timing 2, PHY control, power-management control) in parallel.
- R4: After shadow_load, pd_ack stays low for as long as irq_pending is high.
- R5: pd_ack rises only after sr_enter and shadow_load have occurred and irq_pending was low. Once high, pd_ack stays high until reset, even if pd_req falls.
- R6: After a reset with wake_from_off high, self_refresh and woke are 1, access_en is 0, and no initialization or sr_enter occurs.
- R7: After a wake reset, the block stays in self-refresh with access_en low until a restore_done pulse. sr_exit then pulses for one cycle, and access_en rises exactly exit_cycles+2 cycles after the restore_done sampling edge. woke clears at the same edge.
- R8: phy_clk_en is low only when phy_gate is high and self_refresh is high; outside self-refresh, phy_gate has no effect.
- R9: If pd_req falls during draining, the block returns to service with access_en high the next cycle and issues no self-refresh command. If pd_req falls while waiting for interrupts, sr_exit pulses, pd_ack never rises and access returns after the exit wait. Withdrawal wins over an interrupt clearing in the same cycle.
- R10: At most one of sr_enter, sr_exit, shadow_load and a rising pd_ack occurs in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_from_off | input | 1 | Sampled during reset; 1 = waking from off mode |
| pd_req | input | 1 | Power-down request |
| queues_empty | input | 1 | All transactions done and all FIFOs empty |
| irq_pending | input | 1 | At least one interrupt not yet serviced |
| restore_done | input | 1 | Software pulse: configuration restored after wake |
| exit_cycles | input | EXIT_W | Wait after the self-refresh exit command |
| phy_gate | input | 1 | Request to gate the PHY clock |
| pd_ack | output | 1 | Power-down acknowledge |
| sr_enter | output | 1 | One-cycle self-refresh entry command |
| sr_exit | output | 1 | One-cycle self-refresh exit command |
| shadow_load | output | 1 | One-cycle strobe: copy shadow registers to main registers |
| self_refresh | output | 1 | DRAM is held in self-refresh |
| access_en | output | 1 | Memory accesses allowed |
| woke | output | 1 | Block came up from off mode and has not yet resumed service |
| phy_clk_en | output | 1 | PHY clock enable |

## Verification
Two events can fall in the same cycle during the interrupt wait: the request is withdrawn, and the last interrupt is serviced. The bench drives pd_req low and irq_pending low on the same edge. The scoreboard must then see a self-refresh exit followed by restored access, and never an acknowledge. The same bench checks that a withdrawal during draining produces no self-refresh command at all, and that the wake path holds self-refresh until restore_done arrives.

// File: rtl/mc_offmode_seq.sv
module mc_offmode_seq #(
  parameter int INIT_CYCLES = 16,
  parameter int EXIT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_from_off,
  input  logic              pd_req,
  input  logic              queues_empty,
  input  logic              irq_pending,
  input  logic              restore_done,
  input  logic [EXIT_W-1:0] exit_cycles,
  input  logic              phy_gate,
  output logic              pd_ack,
  output logic              sr_enter,
  output logic              sr_exit,
  output logic              shadow_load,
  output logic              self_refresh,
  output logic              access_en,
  output logic              woke,
  output logic              phy_clk_en
);
  localparam int INIT_W = $clog2(INIT_CYCLES + 1);
  localparam int CNT_W  = (INIT_W > EXIT_W) ? INIT_W : EXIT_W;

  typedef enum logic [3:0] {
    S_INIT, S_IDLE, S_DRAIN, S_SRIN, S_COPY, S_IRQW, S_ACK, S_WAKE, S_SROUT, S_EXIT
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             woke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= wake_from_off ? S_WAKE : S_INIT;
      cnt    <= CNT_W'(INIT_CYCLES - 1);
      woke_q <= wake_from_off;
    end else begin
      case (state)
        S_INIT:  if (cnt == '0) state <= S_IDLE; else cnt <= cnt - 1'b1;
        S_IDLE:  if (pd_req) state <= S_DRAIN;
        S_DRAIN: if (!pd_req) state <= S_IDLE;
                 else if (queues_empty) state <= S_SRIN;
        S_SRIN:  state <= S_COPY;
        S_COPY:  state <= S_IRQW;
        S_IRQW:  if (!pd_req) state <= S_SROUT;
                 else if (!irq_pending) state <= S_ACK;
        S_ACK:   state <= S_ACK;
        S_WAKE:  if (restore_done) state <= S_SROUT;
        S_SROUT: begin
          state <= S_EXIT;
          cnt   <= CNT_W'(exit_cycles);
        end
        S_EXIT:  if (cnt == '0) begin
                   state  <= S_IDLE;
                   woke_q <= 1'b0;
                 end else cnt <= cnt - 1'b1;
        default: state <= S_INIT;
      endcase
    end
  end

  assign pd_ack       = (state == S_ACK);
  assign sr_enter     = (state == S_SRIN);
  assign sr_exit      = (state == S_SROUT);
  assign shadow_load  = (state == S_COPY);
  assign self_refresh = (state == S_COPY) || (state == S_IRQW) ||
                        (state == S_ACK)  || (state == S_WAKE);
  assign access_en    = (state == S_IDLE);
  assign woke         = woke_q;
  assign phy_clk_en   = !(phy_gate && self_refresh);

  assert_enter_after_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_enter) |-> $past(queues_empty) && $past(pd_req));
  assert_copy_after_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_load |-> $past(sr_enter));
  assert_no_ack_with_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_ack) |-> !$past(irq_pending) && $past(self_refresh));
  assert_ack_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pd_ack |=> pd_ack);
  assert_no_access_in_sr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    access_en |-> !self_refresh);
  assert_gate_only_in_sr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_clk_en |-> self_refresh);
  assert_one_command_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_enter, sr_exit, shadow_load, $rose(pd_ack)}));
endmodule

// File: tb/mc_offmode_seq_tb_top.sv
module mc_offmode_seq_tb_top;
  localparam int INIT_CYCLES = 16;
  localparam int EXIT_W      = 8;
  localparam int EV_ENTER = 1, EV_COPY = 2, EV_EXIT = 3, EV_ACK = 4, EV_ACCESS = 5;

  logic clk = 1'b0;
  logic rst_n, wake_from_off, pd_req, queues_empty, irq_pending, restore_done, phy_gate;
  logic [EXIT_W-1:0] exit_cycles;
  logic pd_ack, sr_enter, sr_exit, shadow_load, self_refresh, access_en, woke, phy_clk_en;

  int checks = 0, fails = 0, cycles = 0;
  int exp_q[$];
  logic prev_ack = 1'b0, prev_acc = 1'b0;

  always #5 clk = ~clk;

  mc_offmode_seq #(.INIT_CYCLES(INIT_CYCLES), .EXIT_W(EXIT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wake_from_off(wake_from_off), .pd_req(pd_req),
    .queues_empty(queues_empty), .irq_pending(irq_pending), .restore_done(restore_done),
    .exit_cycles(exit_cycles), .phy_gate(phy_gate), .pd_ack(pd_ack), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .shadow_load(shadow_load), .self_refresh(self_refresh),
    .access_en(access_en), .woke(woke), .phy_clk_en(phy_clk_en));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ev(input int ev);
    exp_q.push_back(ev);
  endtask

  task automatic see_ev(input int ev);
    if (exp_q.size() == 0) chk("R10 scoreboard unexpected event", ev, 0);
    else chk("R10 scoreboard order", ev, exp_q.pop_front());
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (sr_enter) see_ev(EV_ENTER);
      if (shadow_load) see_ev(EV_COPY);
      if (sr_exit) see_ev(EV_EXIT);
      if (pd_ack && !prev_ack) see_ev(EV_ACK);
      if (access_en && !prev_acc) see_ev(EV_ACCESS);
    end
    prev_ack <= pd_ack;
    prev_acc <= access_en;
  end

  task automatic do_reset(input logic wake);
    rst_n = 1'b0; wake_from_off = wake;
    tick(3);
    rst_n = 1'b1; wake_from_off = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wake_from_off = 1'b0; pd_req = 1'b0; queues_empty = 1'b0;
    irq_pending = 1'b0; restore_done = 1'b0; phy_gate = 1'b0; exit_cycles = 8'd5;
    tick(1);
    do_reset(1'b0);
    chk("R1 reset access_en", access_en, 0);
    chk("R1 reset pd_ack", pd_ack, 0);
    chk("R1 reset self_refresh", self_refresh, 0);
    chk("R1 reset woke", woke, 0);
    expect_ev(EV_ACCESS);
    tick(INIT_CYCLES - 1);
    chk("R1 still initializing", access_en, 0);
    tick(1);
    chk("R1 init done", access_en, 1);
    phy_gate = 1'b1; #1;
    chk("R8 gate ignored outside self-refresh", phy_clk_en, 1);
    phy_gate = 1'b0;

    tick(1);
    pd_req = 1'b1;
    tick(6);
    chk("R2 no access while draining", access_en, 0);
    chk("R2 no self-refresh before empty", self_refresh, 0);
    irq_pending = 1'b1; queues_empty = 1'b1;
    expect_ev(EV_ENTER); expect_ev(EV_COPY);
    tick(10);
    chk("R4 no ack while irq pending", pd_ack, 0);
    chk("R3 in self-refresh after copy", self_refresh, 1);
    chk("R3 copy strobe consumed", exp_q.size(), 0);
    phy_gate = 1'b1; #1;
    chk("R8 gate in self-refresh", phy_clk_en, 0);
    expect_ev(EV_ACK);
    irq_pending = 1'b0;
    tick(3);
    chk("R5 acknowledge", pd_ack, 1);
    pd_req = 1'b0;
    tick(4);
    chk("R5 ack sticky after request drop", pd_ack, 1);
    phy_gate = 1'b0;

    queues_empty = 1'b0;
    do_reset(1'b1);
    chk("R6 wake self_refresh", self_refresh, 1);
    chk("R6 wake woke", woke, 1);
    chk("R6 wake no access", access_en, 0);
    tick(30);
    chk("R7 held in self-refresh", self_refresh, 1);
    chk("R7 no access before restore", access_en, 0);
    expect_ev(EV_EXIT); expect_ev(EV_ACCESS);
    restore_done = 1'b1;
    tick(1);
    restore_done = 1'b0;
    tick(5 + 1);
    chk("R7 exit wait not over", access_en, 0);
    tick(1);
    chk("R7 access after exit wait", access_en, 1);
    chk("R7 woke cleared", woke, 0);

    pd_req = 1'b1;
    tick(3);
    chk("R9 draining blocks access", access_en, 0);
    expect_ev(EV_ACCESS);
    pd_req = 1'b0;
    tick(1);
    chk("R9 back to service after drain withdrawal", access_en, 1);
    chk("R9 no self-refresh after drain withdrawal", self_refresh, 0);

    tick(2);
    pd_req = 1'b1; queues_empty = 1'b1; irq_pending = 1'b1;
    expect_ev(EV_ENTER); expect_ev(EV_COPY);
    tick(8);
    expect_ev(EV_EXIT); expect_ev(EV_ACCESS);
    pd_req = 1'b0; irq_pending = 1'b0;
    tick(12);
    chk("R9 withdrawal beats irq clear, no ack", pd_ack, 0);
    chk("R9 access restored", access_en, 1);
    chk("R9 scoreboard drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    chk("watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule